// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps transitions on up to four external capture inputs. Each input is brought into the clock domain by a two-flop synchronizer. A per-channel edge mode then picks which transitions count: none, low-to-high, high-to-low, or both. When a selected transition is seen, the block copies a free-running capture counter into that channel's capture register and sets the channel's interrupt status bit.

The capture counter has its own 5-bit prescaler. It runs only while the global capture enable is set, and it restarts from zero each time capture is enabled. Software programs and reads the block through a simple 32-bit word register port with byte offsets:

- control at 0x50: bit 10 is the capture enable, bits 8:4 are the prescaler.
- interrupt enable at 0x54: bits 4:1 belong to channels 0 to 3.
- interrupt status at 0x58: bits 4:1 belong to channels 0 to 3.
- write-ones acknowledge at 0x5C.
- capture value of channel x at 0x10 + 4·x.
- edge mode of channel x at 0x30 + 4·x.

A single interrupt line combines the enabled status bits.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset every register reads zero, no capture happens and `irq` is low.
- R2: The edge mode register of channel x (offset 0x30 + 4·x) keeps only bits 1:0, with this encoding: 00 = no capture, 01 = rising edges, 10 = falling edges, 11 = both edges. A transition that the mode does not select leaves status and capture value unchanged.
- R3: On a selected edge, the capture register of channel x (offset 0x10 + 4·x) receives the counter value of the cycle in which the synchronized edge is seen. A change on `cap_in` is captured at the third rising clock edge after it; otherwise the register holds its value.
- R4: Control register 0x50 holds the capture enable in bit 10 and the prescaler p in bits 8:4; all other bits read zero. While the enable is clear, no capture happens and the counter is held at zero. While the enable is set, the counter advances once every p+1 clocks, counted from the write that set the enable.
- R5: The capture counter (CNT_W bits) wraps from its maximum value to zero.
- R6: A capture on channel x sets status bit x+1 of register 0x58. Register 0x54 holds the interrupt enables in bits 4:1 (channel x at bit x+1); all other bits read zero.
- R7: Writing register 0x5C clears each status bit whose write-data bit is one. Zero bits, and bits above bit 8, have no effect.
- R8: If a capture and an acknowledge of the same channel fall on the same clock edge, that channel's status bit stays set.
- R9: `irq` is high exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the register word being accessed |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_in | input | NUM_CH | Asynchronous capture inputs |
| irq | output | 1 | Combined interrupt request |

## Verification
A register write takes effect at the clock edge that samples it and can be read back immediately after that edge. A level change on a capture input appears in the status and capture registers at the third rising clock edge after it, and `irq` follows the status register in the same cycle. The bench changes inputs just after an edge and counts every edge with its own counter. It predicts each timestamp as the number of counter ticks between the enabling write and the cycle two edges after the input change, and samples one nanosecond after the expected edge. The acknowledge test puts the write strobe on exactly the edge where the capture lands.

// File: rtl/cap_pkg.sv
// Package: shared constants and types for the edge capture unit.
// Assumes byte addressing of 32-bit words with at most four channels.
package cap_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int PSC_W  = 5;

    localparam logic [ADDR_W-1:0] OFF_CAP_BASE  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_MODE_BASE = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_CTRL      = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_IE        = 8'h54;
    localparam logic [ADDR_W-1:0] OFF_STAT      = 8'h58;
    localparam logic [ADDR_W-1:0] OFF_ACK       = 8'h5C;

    localparam int CTRL_EN_BIT  = 10;
    localparam int CTRL_PSC_LSB = 4;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/cap_edge_sync.sv
// Module: two-flop synchronizer plus one history flop per input.
// Produces single-cycle rise/fall pulses, seen two edges after the input
// is first sampled. Assumes the input stays stable for at least one clock.
module cap_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_pulse,
    output logic fall_pulse
);
    logic meta_q, sync_q, hist_q;

    // Synchronize the pin and keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    // Decode the transition direction from the last two synchronized levels.
    always_comb begin
        rise_pulse = sync_q & ~hist_q;
        fall_pulse = ~sync_q & hist_q;
    end
endmodule

// File: rtl/cap_timebase.sv
// Module: prescaled, free-running capture counter.
// Counts once every (psc+1) clocks while enabled and wraps freely. Held at zero
// while disabled, so each enable starts a fresh timebase.
module cap_timebase #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic [CNT_W-1:0] stamp
);
    logic [PSC_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance the divider and step the counter when the divider reaches psc.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (div_q == psc) begin
            div_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign stamp = cnt_q;

    // While running, the counter only ever moves forward by one (wrap included).
    assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cap_regs.sv
// Module: register file, capture registers, status and interrupt logic.
// Assumes single-cycle writes on bus_wr and a combinational read of bus_addr.
// Channel x status and interrupt enable live at bit x+1.
module cap_regs #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [cap_pkg::ADDR_W-1:0] bus_addr,
    input  logic                       bus_wr,
    input  logic [cap_pkg::DATA_W-1:0] bus_wdata,
    output logic [cap_pkg::DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0]          rise,
    input  logic [NUM_CH-1:0]          fall,
    input  logic [CNT_W-1:0]           stamp,
    output logic                       run,
    output logic [cap_pkg::PSC_W-1:0]  psc,
    output logic                       irq
);
    import cap_pkg::*;

    localparam int PSC_MSB = CTRL_PSC_LSB + PSC_W - 1;

    edge_mode_e        mode_q [NUM_CH];
    logic [CNT_W-1:0]  cap_q  [NUM_CH];
    logic [NUM_CH-1:0] ie_q, st_q, fire, ack_clr;
    logic              en_q;
    logic [PSC_W-1:0]  psc_q;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    // Hold the global enable and the prescaler from the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            psc_q <= '0;
        end else if (bus_wr && bus_addr == OFF_CTRL) begin
            en_q  <= bus_wdata[CTRL_EN_BIT];
            psc_q <= bus_wdata[PSC_MSB:CTRL_PSC_LSB];
        end
    end

    // Hold the per-channel interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= '0;
        else if (bus_wr && bus_addr == OFF_IE)
            ie_q <= bus_wdata[NUM_CH:1];
    end

    // Decode the acknowledge write into per-channel clear bits.
    always_comb begin
        ack_clr = '0;
        if (bus_wr && bus_addr == OFF_ACK)
            ack_clr = bus_wdata[NUM_CH:1];
    end

    // Set status on capture, clear on acknowledge; a capture takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= (st_q & ~ack_clr) | fire;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] MODE_ADDR = OFF_MODE_BASE + ADDR_W'(4 * i);

        // Select the edges this channel reacts to, gated by the global enable.
        always_comb begin
            fire[i] = en_q &&
                (((mode_q[i] == EDGE_RISE || mode_q[i] == EDGE_ANY) && rise[i]) ||
                 ((mode_q[i] == EDGE_FALL || mode_q[i] == EDGE_ANY) && fall[i]));
        end

        // Store the two-bit edge mode of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q[i] <= EDGE_OFF;
            else if (bus_wr && bus_addr == MODE_ADDR)
                mode_q[i] <= edge_mode_e'(bus_wdata[1:0]);
        end

        // Latch the timestamp on a selected edge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cap_q[i] <= '0;
            else if (fire[i])
                cap_q[i] <= stamp;
        end

        assert_cap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !fire[i] |=> $stable(cap_q[i]));
        assert_capture_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> st_q[i]);
        assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_clr[i] && !fire[i]) |=> !st_q[i]);
    end

    // Return the addressed register, zero for unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_CTRL) begin
            bus_rdata[CTRL_EN_BIT]           = en_q;
            bus_rdata[PSC_MSB:CTRL_PSC_LSB] = psc_q;
        end
        if (bus_addr == OFF_IE)
            bus_rdata[NUM_CH:1] = ie_q;
        if (bus_addr == OFF_STAT)
            bus_rdata[NUM_CH:1] = st_q;
        for (int k = 0; k < NUM_CH; k++) begin
            if (bus_addr == OFF_MODE_BASE + ADDR_W'(4 * k))
                bus_rdata[1:0] = mode_q[k];
            if (bus_addr == OFF_CAP_BASE + ADDR_W'(4 * k))
                bus_rdata[CNT_W-1:0] = cap_q[k];
        end
    end

    assign run = en_q;
    assign psc = psc_q;
    assign irq = |(st_q & ie_q);

    assert_no_capture_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (st_q & ~$past(st_q)) == '0);
endmodule

// File: rtl/edge_capture_unit.sv
// Module: top of the edge-selectable input capture unit.
// Wires one synchronizer per channel, the timebase and the register file.
// Assumes 1 <= NUM_CH <= 4 and CNT_W <= 32.
module edge_capture_unit #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] cap_in,
    output logic              irq
);
    logic [NUM_CH-1:0]         rise, fall;
    logic                      run;
    logic [cap_pkg::PSC_W-1:0] psc;
    logic [CNT_W-1:0]          stamp;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sync
        cap_edge_sync u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_async  (cap_in[i]),
            .rise_pulse (rise[i]),
            .fall_pulse (fall[i])
        );
    end

    cap_timebase #(.CNT_W(CNT_W), .PSC_W(cap_pkg::PSC_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .psc   (psc),
        .stamp (stamp)
    );

    cap_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rise      (rise),
        .fall      (fall),
        .stamp     (stamp),
        .run       (run),
        .psc       (psc),
        .irq       (irq)
    );
endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
    localparam int NCH = 4;
    localparam int CW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    cap_in = '0;
    logic              irq;

    int n = 0, checks = 0, errors = 0, en_edge = 0, psc_m = 0;
    bit done = 0;
    logic [31:0] v;
    int model_cap [NCH];

    // Vector: {channel[5:4], mode[3:2], new level[1], capture expected[0]}.
    localparam logic [5:0] VEC [9] = '{
        {2'd0, 2'b01, 1'b1, 1'b1},
        {2'd0, 2'b01, 1'b0, 1'b0},
        {2'd1, 2'b10, 1'b1, 1'b0},
        {2'd1, 2'b10, 1'b0, 1'b1},
        {2'd2, 2'b11, 1'b1, 1'b1},
        {2'd2, 2'b11, 1'b0, 1'b1},
        {2'd3, 2'b00, 1'b1, 1'b0},
        {2'd3, 2'b00, 1'b0, 1'b0},
        {2'd3, 2'b01, 1'b1, 1'b1}
    };

    edge_capture_unit #(.NUM_CH(NCH), .CNT_W(CW)) i_edge_capture_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        n++;
        #1;
    endtask

    task automatic ticks(input int k);
        for (int t = 0; t < k; t++) tick();
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd32(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic enable(input int p);
        wr32(8'h50, 32'h400 | (32'(p) << 4));
        en_edge = n;
        psc_m = p;
    endtask

    function automatic int stamp_at(input int m);
        return ((m - en_edge) / (psc_m + 1)) % (1 << CW);
    endfunction

    task automatic capture_cap(input int ch, input logic lvl, output int j);
        j = n;
        cap_in[ch] = lvl;
        ticks(3);
    endtask

    initial begin
        int j;
        for (int c = 0; c < NCH; c++) model_cap[c] = 0;
        ticks(3);
        rst_n = 1'b1;
        tick();

        // R1: reset state.
        rd32(8'h50, v); check("R1 ctrl", v, 0);
        rd32(8'h54, v); check("R1 ie", v, 0);
        rd32(8'h58, v); check("R1 status", v, 0);
        rd32(8'h10, v); check("R1 cap0", v, 0);
        rd32(8'h30, v); check("R1 mode0", v, 0);
        check("R1 irq", 32'(irq), 0);

        wr32(8'h54, 32'h1E);
        enable(0);

        // Table walk: R2 mode encoding, R3 capture value, R6 status, R9 irq.
        for (int k = 0; k < 9; k++) begin
            int ch;
            ch = int'(VEC[k][5:4]);
            wr32(8'h5C, 32'h1FF);
            wr32(8'(8'h30 + 4 * ch), 32'(VEC[k][3:2]));
            capture_cap(ch, VEC[k][1], j);
            if (VEC[k][0]) model_cap[ch] = stamp_at(j + 2);
            rd32(8'h58, v);
            check("R2 R6 status", v, VEC[k][0] ? (32'h1 << (ch + 1)) : 32'h0);
            rd32(8'(8'h10 + 4 * ch), v);
            check("R3 capture value", v, 32'(model_cap[ch]));
            check("R9 irq", 32'(irq), 32'(VEC[k][0]));
        end

        // R7: zero bits and bits above 8 do not clear.
        wr32(8'h5C, 32'h0);
        rd32(8'h58, v); check("R7 zero ack", v, 32'h10);
        wr32(8'h5C, 32'hFFFF_FE00);
        rd32(8'h58, v); check("R7 high bits ack", v, 32'h10);
        wr32(8'h5C, 32'h10);
        rd32(8'h58, v); check("R7 ack clears", v, 32'h0);

        // R9: irq needs the matching enable bit.
        capture_cap(0, 1'b1, j);
        wr32(8'h54, 32'h04);
        check("R9 irq masked", 32'(irq), 0);
        wr32(8'h54, 32'h02);
        check("R9 irq enabled", 32'(irq), 1);
        wr32(8'h5C, 32'h02);
        check("R9 irq after ack", 32'(irq), 0);

        // R8: capture on ch2 coincides with an acknowledge of everything.
        cap_in[1] = 1'b1; ticks(3);
        capture_cap(1, 1'b0, j);
        rd32(8'h58, v); check("R8 setup ch1", v, 32'h04);
        j = n;
        cap_in[2] = 1'b1;
        ticks(2);
        bus_addr = 8'h5C; bus_wdata = 32'h1FF; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
        model_cap[2] = stamp_at(j + 2);
        rd32(8'h58, v); check("R8 capture beats ack", v, 32'h08);
        rd32(8'h18, v); check("R8 capture value", v, 32'(model_cap[2]));

        // R4: disabled capture does nothing.
        wr32(8'h50, 32'h0);
        wr32(8'h5C, 32'h1FF);
        capture_cap(2, 1'b0, j);
        rd32(8'h58, v); check("R4 no capture when off", v, 32'h0);
        rd32(8'h18, v); check("R4 capture held when off", v, 32'(model_cap[2]));

        // R4: prescaler 3.
        enable(3);
        rd32(8'h50, v); check("R4 ctrl readback", v, 32'h430);
        ticks(10);
        capture_cap(2, 1'b1, j);
        model_cap[2] = stamp_at(j + 2);
        rd32(8'h18, v); check("R4 prescaled stamp", v, 32'(model_cap[2]));

        // R5: counter wraps.
        wr32(8'h50, 32'h0);
        enable(0);
        ticks(300);
        capture_cap(2, 1'b0, j);
        model_cap[2] = stamp_at(j + 2);
        rd32(8'h18, v); check("R5 wrapped stamp", v, 32'(model_cap[2]));

        // Readback widths: R2 mode bits, R6 enable bits, R4 control bits.
        wr32(8'h30, 32'hFFFF_FFFF);
        rd32(8'h30, v); check("R2 mode width", v, 32'h3);
        wr32(8'h54, 32'hFFFF_FFFF);
        rd32(8'h54, v); check("R6 ie width", v, 32'h1E);
        wr32(8'h50, 32'hFFFF_FFFF);
        rd32(8'h50, v); check("R4 ctrl width", v, 32'h5F0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule